// File: doc/BRIEF.md
# Stepped Voltage-Identification Reference Sequencer

This block turns a 5-bit voltage-identification code into the reference setting of a core-voltage regulator. It never jumps between two valid settings. When the code changes, it first checks that the new value holds steady. It then waits a short settling period and walks the reference toward the new target one 25 mV step at a time. The aim is to keep in-rush current and output swings small while the processor changes its supply request on the fly.

All timing counts switching cycles. A one-clock `tick` pulse marks each cycle, and nothing changes between ticks. The reference is given two ways: as a step index (the code value itself) and in millivolts. The all-ones code means "output off". Moves into or out of that code take effect at once, with no ramp. A retarget that arrives mid-ramp is judged against the present intermediate reference:
- If stepping can go on in the same direction, it goes on without a pause.
- If the reference would have to turn around, stepping stops and a fresh settling wait runs first.

Top module: `vid_ref_stepper`

## Requirements
- R1: Code 31 (all ones) sets `off`=1 and `ref_mv`=0. Any code c from 0 to 30 gives `ref_step`=c, `off`=0 and `ref_mv`=1850-25*c.
- R2: While `rst` is high at a clock edge, the reference loads the current `vid_code` directly, and `busy` is 0 afterwards.
- R3: A code counts as a change only when it is seen on two consecutive ticks and differs from the current target. A code held for a single tick is ignored.
- R4: The tick that confirms a change raises `busy`. Two wait ticks follow. The first step lands on the third tick after the confirming tick.
- R5: While ramping, `ref_step` moves by exactly one toward the target on every second tick. `busy` falls on the tick where the reference equals the target.
- R6: A confirmed new valid code that lies in the present direction of travel, as seen from the intermediate reference, replaces the target with no pause in the two-tick step rhythm.
- R7: A confirmed new valid code that needs the opposite direction halts stepping. A new two-tick wait runs, and the next step lands on the third tick after the confirming tick.
- R8: The direction decision compares the new code with the intermediate reference and not with the old target. A code lying between the reference and the old target therefore continues without a pause.
- R9: A confirmed change to code 31, or away from code 31, updates the reference on the confirming tick. This also holds mid-ramp, and `busy` is 0 afterwards.
- R10: Without `tick`, the reference and `busy` keep their values whatever `vid_code` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per switching cycle |
| vid_code | input | 5 | Voltage-identification code |
| ref_step | output | 5 | Present reference as a code index |
| ref_mv | output | 12 | Present reference in millivolts (0 when off) |
| busy | output | 1 | High from change confirmation until the target is reached |
| off | output | 1 | Reference is in the off code |

## Verification
Several properties are checked on every cycle:
- Between two valid codes, the reference never moves by more than one index.
- Two steps never land on back-to-back ticks.
- The reference holds still when no tick occurs.
- An idle sequencer always sits on its target.
- The off code always reads as zero millivolts.
- The reference loads the input code on reset.

Other behaviour depends on history across many ticks, so only the bench scenarios can show it. This covers:
- how long a code must be held before it is confirmed,
- the exact tick of the first step after a wait,
- whether a mid-ramp retarget pauses or carries on,
- the direction decision made against the intermediate value.

// File: rtl/vidref_pkg.sv
package vidref_pkg;

    localparam int VID_W    = 5;
    localparam logic [VID_W-1:0] OFF_CODE = {VID_W{1'b1}};

    typedef logic [VID_W-1:0] vid_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RAMP = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic valid;
        vid_t code;
    } vid_evt_t;

    function automatic int code_to_mv(input vid_t code, input int top_mv, input int step_mv);
        if (code == OFF_CODE) begin
            return 0;
        end
        return top_mv - step_mv * int'(code);
    endfunction

    function automatic vid_t step_toward(input vid_t cur, input vid_t tgt);
        if (tgt > cur) begin
            return cur + vid_t'(1);
        end else if (tgt < cur) begin
            return cur - vid_t'(1);
        end
        return cur;
    endfunction

endpackage

// File: rtl/vidref_sampler.sv
module vidref_sampler
    import vidref_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  vid_t     vid_in,
    input  vid_t     tgt_code,
    output vid_evt_t evt
);
    vid_t samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= vid_in;
        end else if (tick) begin
            samp_q <= vid_in;
        end
    end

    always_comb begin
        evt.code  = vid_in;
        evt.valid = tick && (vid_in == samp_q) && (vid_in != tgt_code);
    end

endmodule

// File: rtl/vidref_seq.sv
module vidref_seq
    import vidref_pkg::*;
#(
    parameter int WAIT_TICKS = 2,
    parameter int STEP_TICKS = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  vid_t     vid_in,
    input  vid_evt_t evt,
    output vid_t     ref_code,
    output vid_t     tgt_code,
    output logic     busy
);
    localparam int MAXT  = (WAIT_TICKS > STEP_TICKS) ? WAIT_TICKS : STEP_TICKS;
    localparam int CNT_W = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_TICKS - 1);
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_TICKS - 1);

    seq_state_e       st_q, st_d;
    vid_t             ref_q, ref_d;
    vid_t             tgt_q, tgt_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             advance;

    always_comb begin
        st_d    = st_q;
        ref_d   = ref_q;
        tgt_d   = tgt_q;
        cnt_d   = cnt_q;
        advance = 1'b0;
        if (tick) begin
            if (evt.valid) begin
                if (evt.code == OFF_CODE || ref_q == OFF_CODE) begin
                    ref_d = evt.code;
                    tgt_d = evt.code;
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else if (evt.code == ref_q) begin
                    tgt_d = evt.code;
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end else if (st_q == ST_IDLE ||
                             ((evt.code > ref_q) != (tgt_q > ref_q))) begin
                    tgt_d = evt.code;
                    st_d  = ST_WAIT;
                    cnt_d = '0;
                end else begin
                    tgt_d   = evt.code;
                    advance = 1'b1;
                end
            end else begin
                advance = 1'b1;
            end
            if (advance) begin
                case (st_q)
                    ST_WAIT: begin
                        if (cnt_q == WAIT_LAST) begin
                            st_d  = ST_RAMP;
                            cnt_d = STEP_LAST;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    ST_RAMP: begin
                        if (cnt_q == STEP_LAST) begin
                            ref_d = step_toward(ref_q, tgt_d);
                            cnt_d = '0;
                            if (ref_d == tgt_d) begin
                                st_d = ST_IDLE;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ref_q <= vid_in;
            tgt_q <= vid_in;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            ref_q <= ref_d;
            tgt_q <= tgt_d;
            cnt_q <= cnt_d;
        end
    end

    assign ref_code = ref_q;
    assign tgt_code = tgt_q;
    assign busy     = (st_q != ST_IDLE);

    // Tracks whether the previous tick moved the reference between valid codes.
    logic moved_last_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            moved_last_q <= 1'b0;
        end else if (tick) begin
            moved_last_q <= (ref_d != ref_q) && (ref_d != OFF_CODE) && (ref_q != OFF_CODE);
        end
    end

    assert_one_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ref_q != OFF_CODE && $past(ref_q) != OFF_CODE && !$past(rst)) |->
        (ref_q == $past(ref_q) || ref_q == $past(ref_q) + vid_t'(1) ||
         ref_q == $past(ref_q) - vid_t'(1)));

    assert_step_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && ref_d != ref_q && ref_d != OFF_CODE && ref_q != OFF_CODE) |-> !moved_last_q);

    assert_idle_settled_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ref_q == tgt_q));

    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(rst)) |-> ($stable(ref_q) && $stable(st_q)));

endmodule

// File: rtl/vidref_fmt.sv
module vidref_fmt
    import vidref_pkg::*;
#(
    parameter int MV_W    = 12,
    parameter int TOP_MV  = 1850,
    parameter int STEP_MV = 25
) (
    input  vid_t            ref_code,
    output logic [MV_W-1:0] ref_mv,
    output logic            off
);
    always_comb begin
        off    = (ref_code == OFF_CODE);
        ref_mv = MV_W'(code_to_mv(ref_code, TOP_MV, STEP_MV));
    end
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper
    import vidref_pkg::*;
#(
    parameter int WAIT_TICKS = 2,
    parameter int STEP_TICKS = 2,
    parameter int MV_W       = 12,
    parameter int TOP_MV     = 1850,
    parameter int STEP_MV    = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [VID_W-1:0]  vid_code,
    output logic [VID_W-1:0]  ref_step,
    output logic [MV_W-1:0]   ref_mv,
    output logic              busy,
    output logic              off
);
    vid_evt_t evt;
    vid_t     tgt_code;
    vid_t     ref_code;

    vidref_sampler u_samp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .vid_in   (vid_code),
        .tgt_code (tgt_code),
        .evt      (evt)
    );

    vidref_seq #(
        .WAIT_TICKS (WAIT_TICKS),
        .STEP_TICKS (STEP_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .vid_in   (vid_code),
        .evt      (evt),
        .ref_code (ref_code),
        .tgt_code (tgt_code),
        .busy     (busy)
    );

    vidref_fmt #(
        .MV_W    (MV_W),
        .TOP_MV  (TOP_MV),
        .STEP_MV (STEP_MV)
    ) u_fmt (
        .ref_code (ref_code),
        .ref_mv   (ref_mv),
        .off      (off)
    );

    assign ref_step = ref_code;

    assert_off_zero_R1: assert property (@(posedge clk) disable iff (rst)
        off |-> (ref_mv == '0));

    assert_reset_load_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ref_step == $past(vid_code) && !busy));

endmodule

// File: tb/sim_vid_ref_stepper.sv
`timescale 1ns/1ps
module sim_vid_ref_stepper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [4:0]  vid_code = 5'd10;
    logic [4:0]  ref_step;
    logic [11:0] ref_mv;
    logic        busy;
    logic        off;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vid_ref_stepper u0 (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .vid_code (vid_code),
        .ref_step (ref_step),
        .ref_mv   (ref_mv),
        .busy     (busy),
        .off      (off)
    );

    localparam int N = 27;
    // Columns: code driven, ticks applied, expected ref_step, expected busy.
    localparam int T_VID [N] = '{12,12,12,12,12,12,12, 20,12, 8,8, 6,6,6, 12,12,4,4,4,4, 12,12,9,9, 31,3,3};
    localparam int T_NT  [N] = '{ 1, 1, 2, 1, 1, 1, 3,  1, 2, 2,3, 2,2,6,  2, 3,2,2,1,4,  2, 3,2,6,  2,1,1};
    localparam int T_EXP [N] = '{10,10,10,11,11,12,12, 12,12,12,11,10,9,6, 6, 7,7,7,6,4,  4, 5,6,9, 31,31,3};
    localparam int T_BSY [N] = '{ 0, 1, 1, 1, 1, 0, 0,  0, 0, 1,1, 1,1,0,  1, 1,1,1,1,0,  1, 1,1,0,  0,0,0};

    function automatic string tag_of(input int i);
        case (i)
            0, 7, 8:              return "R3";
            1, 2, 3, 9, 10:       return "R4";
            4, 5, 6:              return "R5";
            11, 12, 13:           return "R6";
            14, 15, 16, 17, 18, 19: return "R7";
            20, 21, 22, 23:       return "R8";
            default:              return "R9";
        endcase
    endfunction

    function automatic int mv_of(input int code);
        return (code == 31) ? 0 : 1850 - 25 * code;
    endfunction

    task automatic check(input string req, input int exp_code, input int exp_busy);
        n_run++;
        if (int'(ref_step) != exp_code || int'(busy) != exp_busy ||
            int'(ref_mv) != mv_of(exp_code) || int'(off) != int'(exp_code == 31)) begin
            n_fail++;
            $display("FAIL %s: step=%0d busy=%0d mv=%0d off=%0d expected step=%0d busy=%0d mv=%0d off=%0d",
                     req, ref_step, busy, ref_mv, off, exp_code, exp_busy, mv_of(exp_code),
                     int'(exp_code == 31));
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic do_reset(input int code);
        @(negedge clk);
        vid_code = 5'(code);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset(10);
        check("R2", 10, 0);
        check("R1", 10, 0);

        for (int i = 0; i < N; i++) begin
            @(negedge clk) vid_code = 5'(T_VID[i]);
            pulse_ticks(T_NT[i]);
            check(tag_of(i), T_EXP[i], T_BSY[i]);
        end

        // R10: code changes without ticks leave everything unchanged
        @(negedge clk) vid_code = 5'd20;
        repeat (20) @(negedge clk);
        check("R10", 3, 0);
        vid_code = 5'd3;
        pulse_ticks(2);
        check("R10", 3, 0);

        // R9: switching to off while mid-ramp is immediate
        @(negedge clk) vid_code = 5'd10;
        pulse_ticks(2);
        check("R4", 3, 1);
        pulse_ticks(3);
        check("R5", 4, 1);
        @(negedge clk) vid_code = 5'd31;
        pulse_ticks(2);
        check("R9", 31, 0);

        // R1: end codes of the valid range
        do_reset(0);
        check("R1", 0, 0);
        do_reset(30);
        check("R1", 30, 0);

        // R2: reset into the off code
        do_reset(31);
        check("R2", 31, 0);
        do_reset(25);
        check("R2", 25, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule